// File: doc/BRIEF.md
# Codec Serial PCM and Control Port

This block is the digital serial side of a telephone voice codec. It runs on the bit clock and watches an active-low frame strobe. When the strobe is seen low and a two-bit address code enables the port, an 8-cycle channel slot opens. During the slot the block shifts one outgoing PCM word onto a line that has a separate output enable, so that a pad can make the line three-state. It also shifts one incoming PCM word in, and in the same cycles it gathers a serial control byte.

The address code does two jobs. It decides whether the slot opens at all, and it chooses which of two control registers takes the captured control byte. A strap input says how the control pin is being used. The pin can carry a serial byte, or it can be tied high, which selects a fixed default setting, or tied low, which forces powerdown. The effective control image drives powerdown, receive and transmit gain trim, loopback, a two-bit test mode and six system drive lines. When loopback is set, the next slot sends back the last received PCM word.

All state changes on the rising clock edge, and reset is synchronous and active high.

Top module: `pcm_ctl_port`

## Requirements
- R1: While reset is held and just after it, the output enable `pcm_oe` and `rx_valid` are low and `rx_word` is 0. The control outputs show the default image: both gains 2, loopback 0, powerdown 0, test mode 0 and system drive 0.
- R2: A slot opens on a rising edge where `sync_n` is low, `addr_lvl` is 01 or 10, and no slot is already open. `pcm_oe` is high for exactly the 8 cycles that start at that edge, and is low at every other time.
- R3: The outgoing word goes out MSB first. Bit 7 is on `pcm_out` from the opening edge, and each later edge moves on by one bit.
- R4: `pcm_in` is sampled MSB first on the 8 edges that follow the opening edge. At the 8th of those edges `rx_word` takes the full word and `rx_valid` goes high for one cycle.
- R5: Address codes 00 and 11 never open a slot. `sync_n` held low while a slot is open neither restarts nor stretches that slot.
- R6: Strap code 00 or 11 selects serial mode. In serial mode `ctl_in` is sampled on the same edges as `pcm_in`, MSB first. At the 8th edge the byte is written to register A when the slot opened with code 01, and to register B when it opened with code 10. Register A holds bits [7:5] receive gain, [4:2] transmit gain, [1] loopback and [0] powerdown. Register B holds bits [7:6] test mode and [5:0] system drive.
- R7: If `addr_lvl` leaves 01 and 10 while a slot is open, the slot closes at the next edge and `pcm_oe` drops. The partial control byte is not written, `rx_word` keeps its value and `rx_valid` stays low.
- R8: Strap code 01 (pin tied high) makes the outputs show the default image A = 8'h48, B = 8'h00, and writes nothing. The registers keep their contents, and those contents show again when serial mode returns.
- R9: Strap code 10 (pin tied low) makes the outputs show A = 8'h01, B = 8'h00, which means powerdown is on and every other field is 0. It writes nothing.
- R10: If the effective loopback bit is 1 at the opening edge, the slot sends the current `rx_word` instead of `tx_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; everything changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Active-low frame/channel strobe |
| addr_lvl | input | 2 | Address code: 00 off, 01 register A, 10 register B, 11 off |
| ctl_strap | input | 2 | Control pin use: 00/11 serial, 01 tied high, 10 tied low |
| ctl_in | input | 1 | Serial control data |
| pcm_in | input | 1 | Serial incoming PCM data |
| tx_word | input | 8 | Parallel PCM word to transmit |
| pcm_out | output | 1 | Serial outgoing PCM data |
| pcm_oe | output | 1 | Output enable for the three-state line |
| rx_word | output | 8 | Last complete received PCM word |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` updates |
| pwr_down | output | 1 | Powerdown request |
| rx_gain | output | 3 | Receive gain trim |
| tx_gain | output | 3 | Transmit gain trim |
| loopback | output | 1 | Loopback active |
| test_mode | output | 2 | Test mode select |
| sys_drv | output | 6 | System drive levels; inactive is 0 |

## Verification
The assertions assume a few things about the inputs. `ctl_strap` is taken to be static for the length of a slot. `addr_lvl` leaves the enabled codes only to cancel a slot. Nothing is assumed about `sync_n` timing, because the block ignores it during a slot. The stimulus keeps to these rules: it changes the strap and the transmit word only between slots, and it drops the address in mid-slot only in the cases meant to test cancellation. Apart from that, the data, address codes, strap codes and cancel points are drawn at random from a fixed seed, and directed cases cover strobe hold, both tied modes and loopback.

// File: rtl/pcm_ctl_pkg.sv
package pcm_ctl_pkg;

    localparam int WORD_W = 8;
    localparam int CTL_W  = 8;

    typedef enum logic [1:0] {
        STRAP_SERIAL  = 2'b00,
        STRAP_HIGH    = 2'b01,
        STRAP_LOW     = 2'b10,
        STRAP_SERIAL2 = 2'b11
    } strap_e;

    typedef enum logic [1:0] {
        ADDR_OFF   = 2'b00,
        ADDR_REG_A = 2'b01,
        ADDR_REG_B = 2'b10,
        ADDR_OFF2  = 2'b11
    } addr_e;

    typedef struct packed {
        logic [2:0] rx_gain;
        logic [2:0] tx_gain;
        logic       loopback;
        logic       pwr_down;
    } reg_a_t;

    typedef struct packed {
        logic [1:0] test_mode;
        logic [5:0] sys_drv;
    } reg_b_t;

    localparam reg_a_t A_DEFAULT = '{rx_gain: 3'd2, tx_gain: 3'd2, loopback: 1'b0, pwr_down: 1'b0};
    localparam reg_a_t A_FORCED  = '{rx_gain: 3'd0, tx_gain: 3'd0, loopback: 1'b0, pwr_down: 1'b1};
    localparam reg_b_t B_DEFAULT = '{test_mode: 2'd0, sys_drv: 6'd0};

    function automatic logic addr_enabled(input logic [1:0] a);
        return (addr_e'(a) == ADDR_REG_A) || (addr_e'(a) == ADDR_REG_B);
    endfunction

    function automatic logic addr_is_b(input logic [1:0] a);
        return addr_e'(a) == ADDR_REG_B;
    endfunction

    function automatic logic strap_serial(input logic [1:0] s);
        return (strap_e'(s) == STRAP_SERIAL) || (strap_e'(s) == STRAP_SERIAL2);
    endfunction

endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
    import pcm_ctl_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_n,
    input  logic addr_ok,
    output logic slot_start,
    output logic slot_active,
    output logic slot_shift,
    output logic slot_done
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          active_q;
    logic [CW-1:0] cnt_q;

    assign slot_start  = !active_q && !sync_n && addr_ok;
    assign slot_active = active_q;
    assign slot_shift  = active_q && addr_ok;
    assign slot_done   = slot_shift && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (slot_start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q) begin
            if (!addr_ok || slot_done) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_SLOT_OPENS: assert property (@(posedge clk) disable iff (rst)
        slot_start |=> slot_active); // R2
    AST_SLOT_CLOSES: assert property (@(posedge clk) disable iff (rst)
        slot_done |=> !slot_active); // R2
    AST_CANCEL_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (slot_active && !addr_ok) |=> !slot_active); // R7

endmodule

// File: rtl/pcm_serdes.sv
module pcm_serdes
    import pcm_ctl_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    input  logic         done,
    input  logic         ser_in,
    output logic         ser_out,
    output logic [W-1:0] rx_word,
    output logic         rx_valid
);

    logic [W-1:0] tx_sh_q;
    logic [W-1:0] rx_sh_q;

    assign ser_out = tx_sh_q[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh_q  <= '0;
            rx_sh_q  <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= done;
            if (load) begin
                tx_sh_q <= load_word;
            end else if (shift) begin
                tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
            end
            if (shift) begin
                rx_sh_q <= {rx_sh_q[W-2:0], ser_in};
            end
            if (done) begin
                rx_word <= {rx_sh_q[W-2:0], ser_in};
            end
        end
    end

    AST_TX_MSB_ORDER: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (ser_out == $past(tx_sh_q[W-2]))); // R3
    AST_RX_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(rx_word)); // R7

endmodule

// File: rtl/pcm_ctl_regs.sv
module pcm_ctl_regs
    import pcm_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] addr,
    input  logic [1:0] strap,
    input  logic       ctl_in,
    input  logic       shift,
    input  logic       done,
    output reg_a_t     eff_a,
    output reg_b_t     eff_b
);

    logic [CTL_W-1:0] cap_q;
    logic             sel_b_q;
    reg_a_t           a_q;
    reg_b_t           b_q;
    logic             wr;
    logic [CTL_W-1:0] full_word;

    assign wr        = done && strap_serial(strap);
    assign full_word = {cap_q[CTL_W-2:0], ctl_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q   <= '0;
            sel_b_q <= 1'b0;
            a_q     <= A_DEFAULT;
            b_q     <= B_DEFAULT;
        end else begin
            if (start) begin
                sel_b_q <= addr_is_b(addr);
            end
            if (shift) begin
                cap_q <= full_word;
            end
            if (wr) begin
                if (sel_b_q) begin
                    b_q <= reg_b_t'(full_word);
                end else begin
                    a_q <= reg_a_t'(full_word);
                end
            end
        end
    end

    always_comb begin
        unique case (strap_e'(strap))
            STRAP_HIGH: begin
                eff_a = A_DEFAULT;
                eff_b = B_DEFAULT;
            end
            STRAP_LOW: begin
                eff_a = A_FORCED;
                eff_b = B_DEFAULT;
            end
            default: begin
                eff_a = a_q;
                eff_b = b_q;
            end
        endcase
    end

    AST_PARTIAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !done |=> ($stable(a_q) && $stable(b_q))); // R7
    AST_STATIC_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !strap_serial(strap) |=> ($stable(a_q) && $stable(b_q))); // R8

endmodule

// File: rtl/pcm_ctl_port.sv
module pcm_ctl_port
    import pcm_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_n,
    input  logic [1:0] addr_lvl,
    input  logic [1:0] ctl_strap,
    input  logic       ctl_in,
    input  logic       pcm_in,
    input  logic [7:0] tx_word,
    output logic       pcm_out,
    output logic       pcm_oe,
    output logic [7:0] rx_word,
    output logic       rx_valid,
    output logic       pwr_down,
    output logic [2:0] rx_gain,
    output logic [2:0] tx_gain,
    output logic       loopback,
    output logic [1:0] test_mode,
    output logic [5:0] sys_drv
);

    localparam int W = WORD_W;

    logic         addr_ok;
    logic         slot_start;
    logic         slot_active;
    logic         slot_shift;
    logic         slot_done;
    logic [W-1:0] tx_src;
    reg_a_t       eff_a;
    reg_b_t       eff_b;

    assign addr_ok = addr_enabled(addr_lvl);

    pcm_slot_timer #(.W(W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .sync_n      (sync_n),
        .addr_ok     (addr_ok),
        .slot_start  (slot_start),
        .slot_active (slot_active),
        .slot_shift  (slot_shift),
        .slot_done   (slot_done)
    );

    assign tx_src = eff_a.loopback ? rx_word : tx_word;

    pcm_serdes #(.W(W)) u_serdes (
        .clk       (clk),
        .rst       (rst),
        .load      (slot_start),
        .load_word (tx_src),
        .shift     (slot_shift),
        .done      (slot_done),
        .ser_in    (pcm_in),
        .ser_out   (pcm_out),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid)
    );

    pcm_ctl_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .start  (slot_start),
        .addr   (addr_lvl),
        .strap  (ctl_strap),
        .ctl_in (ctl_in),
        .shift  (slot_shift),
        .done   (slot_done),
        .eff_a  (eff_a),
        .eff_b  (eff_b)
    );

    assign pcm_oe    = slot_active;
    assign pwr_down  = eff_a.pwr_down;
    assign rx_gain   = eff_a.rx_gain;
    assign tx_gain   = eff_a.tx_gain;
    assign loopback  = eff_a.loopback;
    assign test_mode = eff_b.test_mode;
    assign sys_drv   = eff_b.sys_drv;

    AST_OE_DROPS_OFF: assert property (@(posedge clk) disable iff (rst)
        (pcm_oe && !addr_enabled(addr_lvl)) |=> !pcm_oe); // R7
    AST_VALID_AFTER_SLOT: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> ($past(pcm_oe) && !pcm_oe)); // R4
    AST_NO_OPEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!pcm_oe && !addr_enabled(addr_lvl)) |=> !pcm_oe); // R5
    AST_TIED_LOW_PD: assert property (@(posedge clk) disable iff (rst)
        (ctl_strap == 2'b10) |-> (pwr_down && (sys_drv == 6'd0))); // R9

endmodule

// File: tb/pcm_ctl_port_test.sv
module pcm_ctl_port_test;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       sync_n;
    logic [1:0] addr_lvl;
    logic [1:0] ctl_strap;
    logic       ctl_in;
    logic       pcm_in;
    logic [7:0] tx_word;
    logic       pcm_out;
    logic       pcm_oe;
    logic [7:0] rx_word;
    logic       rx_valid;
    logic       pwr_down;
    logic [2:0] rx_gain;
    logic [2:0] tx_gain;
    logic       loopback;
    logic [1:0] test_mode;
    logic [5:0] sys_drv;

    int checks   = 0;
    int failures = 0;

    logic [7:0] m_a  = 8'h48;
    logic [7:0] m_b  = 8'h00;
    logic [7:0] m_rx = 8'h00;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pcm_ctl_port uut (
        .clk(clk), .rst(rst), .sync_n(sync_n), .addr_lvl(addr_lvl),
        .ctl_strap(ctl_strap), .ctl_in(ctl_in), .pcm_in(pcm_in),
        .tx_word(tx_word), .pcm_out(pcm_out), .pcm_oe(pcm_oe),
        .rx_word(rx_word), .rx_valid(rx_valid), .pwr_down(pwr_down),
        .rx_gain(rx_gain), .tx_gain(tx_gain), .loopback(loopback),
        .test_mode(test_mode), .sys_drv(sys_drv)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_a(input logic [1:0] st);
        if (st == 2'b01) return 8'h48;
        if (st == 2'b10) return 8'h01;
        return m_a;
    endfunction

    function automatic logic [7:0] exp_b(input logic [1:0] st);
        if (st == 2'b01 || st == 2'b10) return 8'h00;
        return m_b;
    endfunction

    task automatic check_ctl(input string req);
        logic [7:0] ga;
        logic [7:0] gb;
        ga = {rx_gain, tx_gain, loopback, pwr_down};
        gb = {test_mode, sys_drv};
        chk(ga == exp_a(ctl_strap), {req, " regA image"}, 32'(ga), 32'(exp_a(ctl_strap)));
        chk(gb == exp_b(ctl_strap), {req, " regB image"}, 32'(gb), 32'(exp_b(ctl_strap)));
    endtask

    // One slot attempt; cancel_at < 0 means no cancel. Called at a negedge.
    task automatic do_slot(input logic [1:0] a, input logic [1:0] st, input logic [7:0] txw,
                           input logic [7:0] rxw, input logic [7:0] cw,
                           input int cancel_at, input bit hold_sync, input string req);
        logic [7:0] exp_tx;
        bit en;
        bit cancelled;
        en = (a == 2'b01) || (a == 2'b10);
        addr_lvl  = a;
        ctl_strap = st;
        tx_word   = txw;
        exp_tx    = exp_a(st)[1] ? m_rx : txw;
        sync_n    = 1'b0;
        @(negedge clk);
        if (!hold_sync) sync_n = 1'b1;
        if (!en) begin
            sync_n = 1'b1;
            chk(pcm_oe == 1'b0, "R5 off code opens no slot", 32'(pcm_oe), 0);
            return;
        end
        cancelled = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (!cancelled) begin
                if (i == cancel_at) begin
                    addr_lvl = 2'b00;
                    @(negedge clk);
                    chk(pcm_oe == 1'b0, "R7 oe low after cancel", 32'(pcm_oe), 0);
                    cancelled = 1'b1;
                end else begin
                    chk(pcm_oe == 1'b1, {req, " R2 oe high in slot"}, 32'(pcm_oe), 1);
                    chk(pcm_out == exp_tx[7-i], {req, " R3/R10 tx bit"}, 32'(pcm_out), 32'(exp_tx[7-i]));
                    pcm_in = rxw[7-i];
                    ctl_in = cw[7-i];
                    @(negedge clk);
                end
            end
        end
        sync_n = 1'b1;
        if (cancelled) begin
            chk(rx_valid == 1'b0, "R7 no rx_valid on cancel", 32'(rx_valid), 0);
            chk(rx_word == m_rx, "R7 rx_word kept", 32'(rx_word), 32'(m_rx));
            check_ctl("R7 no partial write");
        end else begin
            chk(pcm_oe == 1'b0, {req, " R2 oe low after 8"}, 32'(pcm_oe), 0);
            chk(rx_valid == 1'b1, {req, " R4 rx_valid"}, 32'(rx_valid), 1);
            chk(rx_word == rxw, {req, " R4 rx_word"}, 32'(rx_word), 32'(rxw));
            m_rx = rxw;
            if (st == 2'b00 || st == 2'b11) begin
                if (a == 2'b01) m_a = cw;
                else m_b = cw;
            end
            check_ctl({req, " R6/R8/R9 control"});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; sync_n = 1'b1; addr_lvl = 2'b00; ctl_strap = 2'b00;
        ctl_in = 1'b0; pcm_in = 1'b0; tx_word = 8'h00;
        repeat (3) @(negedge clk);
        chk(pcm_oe == 1'b0, "R1 oe in reset", 32'(pcm_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(pcm_oe == 1'b0, "R1 oe after reset", 32'(pcm_oe), 0);
        chk(rx_valid == 1'b0, "R1 rx_valid after reset", 32'(rx_valid), 0);
        chk(rx_word == 8'h00, "R1 rx_word after reset", 32'(rx_word), 0);
        check_ctl("R1 default image");

        // R6 directed writes into A then B
        do_slot(2'b01, 2'b00, 8'hA5, 8'h3C, 8'hAC, -1, 1'b0, "R6 write A");
        do_slot(2'b10, 2'b00, 8'h81, 8'hC3, 8'hC5, -1, 1'b0, "R6 write B");
        // R5 off codes
        do_slot(2'b00, 2'b00, 8'hFF, 8'h00, 8'h00, -1, 1'b0, "R5 code 00");
        do_slot(2'b11, 2'b00, 8'hFF, 8'h00, 8'h00, -1, 1'b0, "R5 code 11");
        // R5 strobe held low for the whole slot
        do_slot(2'b10, 2'b00, 8'h5A, 8'h96, 8'h2B, -1, 1'b1, "R5 sync held");
        // R7 cancel mid slot
        do_slot(2'b01, 2'b00, 8'h11, 8'hEE, 8'hFF, 4, 1'b0, "R7 cancel");
        // R8 tied high: no write, registers return afterwards
        do_slot(2'b01, 2'b01, 8'h22, 8'h44, 8'h03, -1, 1'b0, "R8 tied high");
        ctl_strap = 2'b00;
        @(negedge clk);
        check_ctl("R8 registers back in serial");
        // R9 tied low
        do_slot(2'b10, 2'b10, 8'h33, 8'h77, 8'hFF, -1, 1'b0, "R9 tied low");
        chk(pwr_down == 1'b1, "R9 powerdown forced", 32'(pwr_down), 1);
        // R10 loopback: set bit 1 of A, then next slot returns last received word
        do_slot(2'b01, 2'b00, 8'h00, 8'hD2, 8'h4A, -1, 1'b0, "R10 enable loopback");
        do_slot(2'b10, 2'b00, 8'h0F, 8'h61, 8'h00, -1, 1'b0, "R10 looped word");
        do_slot(2'b01, 2'b00, 8'h0F, 8'h18, 8'h48, -1, 1'b0, "R10 clear loopback");

        for (int n = 0; n < 300; n++) begin
            logic [1:0] a;
            logic [1:0] st;
            int ca;
            a  = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) != 0) a = ($urandom_range(0, 1) != 0) ? 2'b01 : 2'b10;
            st = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
            ca = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 7)) : -1;
            do_slot(a, st, 8'($urandom), 8'($urandom), 8'($urandom), ca, 1'b0, "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule